// File: doc/BRIEF.md
# SIMD Warp Issue Scheduler

This block decides which warp uses an 8-lane SIMD datapath on each clock cycle. It holds up to 24 warp contexts. Each context has a program counter, a 32-bit thread mask and a ready flag. A warp of 32 threads cannot fit on 8 lanes in one cycle, so each selected warp is issued over four consecutive beats of 8 threads each. The choice of the next warp is made only at a beat-sequence boundary. Consecutive warp slots may therefore come from different contexts, which gives fine-grained interleaving.

Software or a front-end loads a context through a single write port that carries the warp index, the start PC and the thread mask. It then marks the warp ready with a per-warp set pulse. The issue outputs are all registered. They carry a valid flag, the warp index, the beat number, the 8-bit lane mask for that beat and the PC. After the fourth beat the warp's PC advances by one. While the warp stays ready it is eligible again with the new PC. A per-warp clear pulse withdraws a warp from future selection.

Top module: `warp_issue_sched`

## Requirements
- R1: After reset, `iss_valid` is low and every ready flag is clear. No issue occurs until a warp is marked ready.
- R2: A context write with `ctx_wr_en` high stores `ctx_wr_pc` and `ctx_wr_mask` for warp `ctx_wr_id` on the clock edge. The later issues of that warp carry exactly these values.
- R3: A warp's ready flag is set by its bit of `rdy_set` and cleared by its bit of `rdy_clr`. When both bits are high in the same cycle, the clear wins. A warp whose flag is set at edge E can first be issued (beat 0 visible) at edge E+1.
- R4: A selected warp issues on 4 consecutive cycles with `iss_beat` = 0, 1, 2, 3 in order. The warp index and PC stay the same across all 4 beats.
- R5: In beat k, `iss_mask` equals bits [8k+7:8k] of the warp's thread mask. A beat whose mask is zero is still issued with `iss_valid` high.
- R6: After beat 3 of a warp has issued, that warp's PC is one larger, modulo 2^16. Its next slot shows the incremented value.
- R7: At a boundary the scheduler selects the first ready warp found by searching upward from the last selected warp plus one, wrapping past 23 to 0. After reset the search starts at warp 0.
- R8: If some warp is ready at the boundary, its beat 0 follows the previous beat 3 on the very next cycle, with no gap.
- R9: Clearing the ready flag of the warp being issued does not cut its sequence short. Its remaining beats still issue.
- R10: If no warp is ready at a boundary, the scheduler outputs a cycle with `iss_valid` low and repeats the selection on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ctx_wr_en | input | 1 | Context write strobe |
| ctx_wr_id | input | 5 | Warp index for the context write |
| ctx_wr_pc | input | 16 | Start PC to store |
| ctx_wr_mask | input | 32 | Thread mask to store |
| rdy_set | input | 24 | Per-warp ready set pulses |
| rdy_clr | input | 24 | Per-warp ready clear pulses (win over set) |
| iss_valid | output | 1 | A beat is issued this cycle |
| iss_warp | output | 5 | Warp index of the issued beat (last selected warp when idle) |
| iss_beat | output | 2 | Beat number 0 to 3 within the warp instruction |
| iss_mask | output | 8 | Active lane mask for this beat |
| iss_pc | output | 16 | PC of the issued warp instruction |

## Verification
The checker assumes that the context of a warp is never rewritten while that warp is ready or in flight. Under this assumption, the PC seen on a back-to-back repeat of the same warp can only come from the increment and not from a new load. The bench respects the assumption. It loads every context while the warp is idle and only afterwards raises the set pulse. It also clears each warp at the beat 0 of its final wanted slot, so the rest of the run stays deterministic. Ready flags are the only internal state the checker observes. It uses them to confirm that each beat 0 comes from a ready warp and that a boundary with no ready warp produces a bubble.

// File: rtl/warp_sched_pkg.sv
package warp_sched_pkg;
  // Default geometry of the scheduler
  localparam int unsigned WS_WARPS   = 24;
  localparam int unsigned WS_LANES   = 8;
  localparam int unsigned WS_THREADS = 32;
  localparam int unsigned WS_PC_W    = 16;
endpackage

// File: rtl/warp_ready_flags.sv
module warp_ready_flags #(
  parameter int NUM_WARPS = 24
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [NUM_WARPS-1:0] set_i,
  input  logic [NUM_WARPS-1:0] clr_i,
  output logic [NUM_WARPS-1:0] ready_o
);
  // clear dominates a simultaneous set
  always_ff @(posedge clk) begin
    if (rst) ready_o <= '0;
    else     ready_o <= (ready_o | set_i) & ~clr_i;
  end
endmodule

// File: rtl/warp_ctx_store.sv
module warp_ctx_store #(
  parameter int NUM_WARPS = 24,
  parameter int THREADS   = 32,
  parameter int PC_W      = 16,
  parameter int WID_W     = 5
) (
  input  logic               clk,
  input  logic               wr_en,
  input  logic [WID_W-1:0]   wr_id,
  input  logic [PC_W-1:0]    wr_pc,
  input  logic [THREADS-1:0] wr_mask,
  input  logic               inc_en,
  input  logic [WID_W-1:0]   inc_id,
  input  logic [WID_W-1:0]   rd_id,
  output logic [PC_W-1:0]    rd_pc,
  output logic [THREADS-1:0] rd_mask
);
  logic [PC_W-1:0]    pc_mem   [NUM_WARPS];
  logic [THREADS-1:0] mask_mem [NUM_WARPS];

  always_ff @(posedge clk) begin
    if (wr_en && int'(wr_id) < NUM_WARPS) mask_mem[wr_id] <= wr_mask;
  end

  // a load of a new PC takes priority over the post-sequence increment
  always_ff @(posedge clk) begin
    if (wr_en && int'(wr_id) < NUM_WARPS)
      pc_mem[wr_id] <= wr_pc;
    else if (inc_en && int'(inc_id) < NUM_WARPS)
      pc_mem[inc_id] <= pc_mem[inc_id] + 1'b1;
  end

  assign rd_pc   = pc_mem[rd_id];
  assign rd_mask = mask_mem[rd_id];
endmodule

// File: rtl/warp_rr_pick.sv
module warp_rr_pick #(
  parameter int NUM_WARPS = 24,
  parameter int WID_W     = 5
) (
  input  logic [NUM_WARPS-1:0] ready_i,
  input  logic [WID_W-1:0]     last_i,
  output logic                 found_o,
  output logic [WID_W-1:0]     pick_o
);
  // search begins one past the previous grant and wraps around
  always_comb begin
    found_o = 1'b0;
    pick_o  = last_i;
    for (int k = 1; k <= NUM_WARPS; k++) begin
      int idx;
      idx = (int'(last_i) + k) % NUM_WARPS;
      if (!found_o && ready_i[idx]) begin
        found_o = 1'b1;
        pick_o  = WID_W'(idx);
      end
    end
  end
endmodule

// File: rtl/warp_issue_sched.sv
module warp_issue_sched
  import warp_sched_pkg::*;
#(
  parameter int NUM_WARPS = WS_WARPS,
  parameter int LANES     = WS_LANES,
  parameter int THREADS   = WS_THREADS,
  parameter int PC_W      = WS_PC_W,
  localparam int BEATS    = THREADS / LANES,
  localparam int BEAT_W   = (BEATS > 1) ? $clog2(BEATS) : 1,
  localparam int WID_W    = (NUM_WARPS > 1) ? $clog2(NUM_WARPS) : 1
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 ctx_wr_en,
  input  logic [WID_W-1:0]     ctx_wr_id,
  input  logic [PC_W-1:0]      ctx_wr_pc,
  input  logic [THREADS-1:0]   ctx_wr_mask,
  input  logic [NUM_WARPS-1:0] rdy_set,
  input  logic [NUM_WARPS-1:0] rdy_clr,
  output logic                 iss_valid,
  output logic [WID_W-1:0]     iss_warp,
  output logic [BEAT_W-1:0]    iss_beat,
  output logic [LANES-1:0]     iss_mask,
  output logic [PC_W-1:0]      iss_pc
);
  logic [NUM_WARPS-1:0] ready_q;
  logic                 found;
  logic [WID_W-1:0]     pick;
  logic                 last_beat, boundary;
  logic                 nxt_valid;
  logic [WID_W-1:0]     nxt_warp;
  logic [BEAT_W-1:0]    nxt_beat;
  logic [PC_W-1:0]      rd_pc, nxt_pc;
  logic [THREADS-1:0]   rd_mask;

  warp_ready_flags #(.NUM_WARPS(NUM_WARPS)) u_ready (
    .clk(clk), .rst(rst), .set_i(rdy_set), .clr_i(rdy_clr), .ready_o(ready_q)
  );

  warp_rr_pick #(.NUM_WARPS(NUM_WARPS), .WID_W(WID_W)) u_pick (
    .ready_i(ready_q), .last_i(iss_warp), .found_o(found), .pick_o(pick)
  );

  warp_ctx_store #(
    .NUM_WARPS(NUM_WARPS), .THREADS(THREADS), .PC_W(PC_W), .WID_W(WID_W)
  ) u_ctx (
    .clk(clk), .wr_en(ctx_wr_en), .wr_id(ctx_wr_id), .wr_pc(ctx_wr_pc),
    .wr_mask(ctx_wr_mask), .inc_en(last_beat), .inc_id(iss_warp),
    .rd_id(nxt_warp), .rd_pc(rd_pc), .rd_mask(rd_mask)
  );

  assign last_beat = iss_valid && (iss_beat == BEAT_W'(BEATS - 1));
  assign boundary  = !iss_valid || last_beat;

  always_comb begin
    nxt_valid = boundary ? found : 1'b1;
    nxt_warp  = (boundary && found) ? pick : iss_warp;
    nxt_beat  = boundary ? '0 : iss_beat + 1'b1;
    // same warp reselected: the stored PC updates on this very edge
    if (last_beat && nxt_warp == iss_warp) nxt_pc = rd_pc + 1'b1;
    else                                    nxt_pc = rd_pc;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      iss_valid <= 1'b0;
      iss_warp  <= WID_W'(NUM_WARPS - 1);
      iss_beat  <= '0;
      iss_mask  <= '0;
      iss_pc    <= '0;
    end else begin
      iss_valid <= nxt_valid;
      iss_warp  <= nxt_warp;
      iss_beat  <= nxt_beat;
      iss_mask  <= rd_mask[int'(nxt_beat) * LANES +: LANES];
      if (boundary) iss_pc <= nxt_pc;
    end
  end
endmodule

// File: rtl/warp_issue_sched_chk.sv
module warp_issue_sched_chk #(
  parameter int NUM_WARPS = 24,
  parameter int BEATS     = 4,
  parameter int BEAT_W    = 2,
  parameter int WID_W     = 5,
  parameter int PC_W      = 16
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 iss_valid,
  input logic [WID_W-1:0]     iss_warp,
  input logic [BEAT_W-1:0]    iss_beat,
  input logic [PC_W-1:0]      iss_pc,
  input logic [NUM_WARPS-1:0] ready_q
);
  // R4 R9
  beat_step_chk: assert property (@(posedge clk) disable iff (rst)
    (iss_valid && iss_beat != BEAT_W'(BEATS - 1)) |=>
      (iss_valid && iss_beat == BEAT_W'($past(iss_beat) + 1'b1) &&
       iss_warp == $past(iss_warp) && iss_pc == $past(iss_pc)));

  // R10
  first_beat_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(iss_valid) |-> iss_beat == '0);

  // R7
  pick_ready_chk: assert property (@(posedge clk) disable iff (rst)
    (iss_valid && iss_beat == '0) |-> ((($past(ready_q) >> iss_warp) & 1) != 0));

  // R10
  idle_bubble_chk: assert property (@(posedge clk) disable iff (rst)
    ((!iss_valid || iss_beat == BEAT_W'(BEATS - 1)) && ready_q == '0) |=> !iss_valid);

  // R8
  back_to_back_chk: assert property (@(posedge clk) disable iff (rst)
    (iss_valid && iss_beat == BEAT_W'(BEATS - 1) && ready_q != '0) |=>
      (iss_valid && iss_beat == '0));

  // R6
  pc_advance_chk: assert property (@(posedge clk) disable iff (rst)
    (iss_valid && iss_beat == '0 && $past(iss_valid) &&
     $past(iss_beat) == BEAT_W'(BEATS - 1) && iss_warp == $past(iss_warp)) |->
      iss_pc == PC_W'($past(iss_pc) + 1'b1));
endmodule

bind warp_issue_sched warp_issue_sched_chk #(
  .NUM_WARPS(NUM_WARPS), .BEATS(BEATS), .BEAT_W(BEAT_W), .WID_W(WID_W), .PC_W(PC_W)
) u_chk (
  .clk(clk), .rst(rst), .iss_valid(iss_valid), .iss_warp(iss_warp),
  .iss_beat(iss_beat), .iss_pc(iss_pc), .ready_q(ready_q)
);

// File: tb/tb_warp_issue_sched.sv
module tb_warp_issue_sched;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        ctx_wr_en = 1'b0;
  logic [4:0]  ctx_wr_id = '0;
  logic [15:0] ctx_wr_pc = '0;
  logic [31:0] ctx_wr_mask = '0;
  logic [23:0] rdy_set = '0;
  logic [23:0] rdy_clr = '0;
  logic        iss_valid;
  logic [4:0]  iss_warp;
  logic [1:0]  iss_beat;
  logic [7:0]  iss_mask;
  logic [15:0] iss_pc;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk; // 50 MHz

  warp_issue_sched dut (
    .clk(clk), .rst(rst), .ctx_wr_en(ctx_wr_en), .ctx_wr_id(ctx_wr_id),
    .ctx_wr_pc(ctx_wr_pc), .ctx_wr_mask(ctx_wr_mask), .rdy_set(rdy_set),
    .rdy_clr(rdy_clr), .iss_valid(iss_valid), .iss_warp(iss_warp),
    .iss_beat(iss_beat), .iss_mask(iss_mask), .iss_pc(iss_pc)
  );

  task automatic expect_issue(input logic v, input int w, input int b,
                              input logic [7:0] m, input logic [15:0] pc,
                              input string req);
    bit bad;
    checks++;
    bad = (iss_valid !== v);
    if (v && !bad)
      bad = (iss_warp !== 5'(w)) || (iss_beat !== 2'(b)) ||
            (iss_mask !== m) || (iss_pc !== pc);
    if (bad) begin
      errors++;
      $display("FAIL %s: got v=%0b w=%0d b=%0d m=%h pc=%h exp v=%0b w=%0d b=%0d m=%h pc=%h",
               req, iss_valid, iss_warp, iss_beat, iss_mask, iss_pc, v, w, b, m, pc);
    end
  endtask

  task automatic write_ctx(input int w, input logic [15:0] pc, input logic [31:0] tm);
    @(negedge clk);
    ctx_wr_en = 1'b1; ctx_wr_id = 5'(w); ctx_wr_pc = pc; ctx_wr_mask = tm;
    @(negedge clk);
    ctx_wr_en = 1'b0;
  endtask

  // four beats of one slot; optional clear pulse driven at beat 0
  task automatic run_slot(input int w, input logic [31:0] tm, input logic [15:0] pc,
                          input logic [23:0] clr, input string req);
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      expect_issue(1'b1, w, k, tm[8*k +: 8], pc, req);
      rdy_clr = (k == 0) ? clr : '0;
    end
  endtask

  task automatic set_ready(input logic [23:0] bits);
    @(negedge clk);
    rdy_set = bits;
    @(negedge clk);
    rdy_set = '0;
    expect_issue(1'b0, 0, 0, 8'h00, 16'h0, "R3 not before next edge");
  endtask

  task automatic sc_reset;
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      expect_issue(1'b0, 0, 0, 8'h00, 16'h0, "R1 idle after reset");
    end
    write_ctx(2, 16'h0200, 32'h1122_3344);
    write_ctx(20, 16'h0A00, 32'hDEAD_BEEF);
    // R7: first search after reset starts at warp 0 -> 2 then 20
    set_ready(24'(1 << 2) | 24'(1 << 20));
    run_slot(2, 32'h1122_3344, 16'h0200, '0, "R7 first grant after reset");
    run_slot(20, 32'hDEAD_BEEF, 16'h0A00, 24'(1 << 2) | 24'(1 << 20), "R8 R7 next grant");
    @(negedge clk);
    expect_issue(1'b0, 0, 0, 8'h00, 16'h0, "R10 bubble when none ready");
  endtask

  task automatic sc_single;
    write_ctx(3, 16'h0010, 32'h00A5_FF01);
    set_ready(24'(1 << 3));
    run_slot(3, 32'h00A5_FF01, 16'h0010, '0, "R2 R4 R5 first slot");
    // R9: cleared at beat 0, the slot still completes
    run_slot(3, 32'h00A5_FF01, 16'h0011, 24'(1 << 3), "R6 R8 R9 repeat slot");
    @(negedge clk);
    expect_issue(1'b0, 0, 0, 8'h00, 16'h0, "R10 bubble after clear");
    @(negedge clk);
    expect_issue(1'b0, 0, 0, 8'h00, 16'h0, "R10 retry still idle");
  endtask

  task automatic sc_round_robin;
    write_ctx(0, 16'h1000, 32'h0403_0201);
    write_ctx(5, 16'h5000, 32'hF0F0_0F0F);
    write_ctx(23, 16'h2300, 32'h8000_0001);
    set_ready(24'(1 << 0) | 24'(1 << 5) | 24'(1 << 23));
    // last grant was 3: order 5, 23, 0, 5
    run_slot(5, 32'hF0F0_0F0F, 16'h5000, '0, "R7 rr grant 5");
    run_slot(23, 32'h8000_0001, 16'h2300, '0, "R7 rr grant 23");
    run_slot(0, 32'h0403_0201, 16'h1000, '0, "R7 rr wrap to 0");
    run_slot(5, 32'hF0F0_0F0F, 16'h5001, 24'(1 << 0) | 24'(1 << 5) | 24'(1 << 23),
             "R6 R7 rr back to 5");
    @(negedge clk);
    expect_issue(1'b0, 0, 0, 8'h00, 16'h0, "R10 bubble after rr");
  endtask

  task automatic sc_clear_wins;
    write_ctx(7, 16'h0700, 32'h7777_0000);
    @(negedge clk);
    rdy_set = 24'(1 << 7); rdy_clr = 24'(1 << 7);
    @(negedge clk);
    rdy_set = '0; rdy_clr = '0;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      expect_issue(1'b0, 0, 0, 8'h00, 16'h0, "R3 clear wins over set");
    end
    set_ready(24'(1 << 7));
    run_slot(7, 32'h7777_0000, 16'h0700, 24'(1 << 7), "R3 R5 set alone issues");
    @(negedge clk);
    expect_issue(1'b0, 0, 0, 8'h00, 16'h0, "R10 idle after warp 7");
  endtask

  task automatic sc_pc_wrap;
    write_ctx(12, 16'hFFFF, 32'hFFFF_FFFF);
    set_ready(24'(1 << 12));
    run_slot(12, 32'hFFFF_FFFF, 16'hFFFF, '0, "R6 before wrap");
    run_slot(12, 32'hFFFF_FFFF, 16'h0000, 24'(1 << 12), "R6 pc wraps");
    @(negedge clk);
    expect_issue(1'b0, 0, 0, 8'h00, 16'h0, "R10 idle at end");
  endtask

  initial begin
    sc_reset();
    sc_single();
    sc_round_robin();
    sc_clear_wins();
    sc_pc_wrap();
    if (!done) begin
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog: got running exp finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule